// File: doc/BRIEF.md
# Open-Loop Bridge PWM Controller

This block chops a full-bridge DC motor drive at a fixed frequency with no current or speed feedback. A free-running digital ramp climbs from zero to a fixed top count and then restarts at once. While the ramp is below a duty threshold the bridge is in its on phase; from the threshold up to the top it is in its off phase. Two thresholds are fixed at build time as ramp counts: a high level with a long on time and a low level with a long off time. A select input picks which one applies, and a second select bit can turn chopping off so the bridge drives fully on.

Two direction inputs set how the motor turns. The first drives bridge leg A to supply and leg B to ground; the second does the reverse. Both low lets the bridge float, and both high brakes the motor by tying both legs to ground. A flag output pulls its pin low whenever the low duty level is selected and releases it otherwise. The leg states, the flag and the ramp are all registered.

Top module: `bridge_pwm`

## Requirements
- R1: While reset is asserted, both leg outputs read 2'b00 (tristate) and the flag output is 0 (released). The ramp restarts at count 0.
- R2: The ramp advances by one count per clock from 0 to RAMP_TOP and then returns to 0, so the chopping period is RAMP_TOP+1 clocks.
- R3: With both direction inputs at 0, both legs read 2'b00 (tristate), whatever the duty select and the ramp are.
- R4: With dir_fwd=1 and dir_rev=0, in the on phase leg A reads 2'b01 (tied to supply) and leg B reads 2'b10 (tied to ground).
- R5: With dir_fwd=0 and dir_rev=1, in the on phase leg A reads 2'b10 and leg B reads 2'b01.
- R6: In the off phase of a single-direction drive, the leg that was tied to supply goes to 2'b00 and the other leg stays at 2'b10.
- R7: When duty_sel[1]=1, the on phase holds while the ramp count is below the threshold. duty_sel[0]=1 picks THR_HI and duty_sel[0]=0 picks THR_LO.
- R8: When duty_sel[1]=0 there is no chopping, and a single-direction drive stays in the on phase for the whole ramp period.
- R9: With both direction inputs at 1, both legs read 2'b10 (brake), with no chopping.
- R10: Each output is registered. It reflects the inputs and the ramp count sampled at the clock edge that produces it. The flag reads 1 (pulling low) exactly when duty_sel[0] was 0 at that edge.
- R11: No leg output ever reads 2'b11. The design has no way to turn on both switches of one leg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_fwd | input | 1 | Direction input 1: leg A is the chopped supply leg |
| dir_rev | input | 1 | Direction input 2: leg B is the chopped supply leg |
| duty_sel | input | 2 | Bit 1 enables chopping; bit 0 picks the high (1) or low (0) threshold |
| leg_a | output | 2 | Leg A state: 00 tristate, 01 supply, 10 ground |
| leg_b | output | 2 | Leg B state: 00 tristate, 01 supply, 10 ground |
| lvl_low_pull | output | 1 | 1 pulls the flag pin low because the low duty level is selected; 0 releases it |

## Verification
The hardest cases to reach are the threshold crossings when the selection changes partway through a ramp period. If the select or the direction changes while the ramp sits between the two thresholds, the phase must switch in the very next registered output. The stimulus holds each setting for several whole periods with a short ramp top, so that every threshold edge is crossed in both directions. It then switches direction and select every few cycles from a pseudo-random sequence, which lands changes at arbitrary ramp counts, including some between the two thresholds. A reset applied in mid-run checks that the ramp restarts from zero.

// File: rtl/bridge_pwm.sv
module bridge_pwm #(
  parameter int RAMP_TOP = 2272,
  parameter int THR_HI   = 1515,
  parameter int THR_LO   = 600,
  parameter int MIN_THR  = 200,
  localparam int RW      = $clog2(RAMP_TOP + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dir_fwd,
  input  logic       dir_rev,
  input  logic [1:0] duty_sel,
  output logic [1:0] leg_a,
  output logic [1:0] leg_b,
  output logic       lvl_low_pull
);

  localparam logic [1:0] LEG_OFF = 2'b00;
  localparam logic [1:0] LEG_HI  = 2'b01;
  localparam logic [1:0] LEG_LO  = 2'b10;
  localparam logic [RW-1:0] TOP_C = RW'(RAMP_TOP);
  localparam logic [RW-1:0] HI_C  = RW'(THR_HI);
  localparam logic [RW-1:0] LO_C  = RW'(THR_LO);

  initial begin
    assert_param_order_R7 : assert (MIN_THR <= THR_LO && THR_LO < THR_HI && THR_HI <= RAMP_TOP);
  end

  logic [RW-1:0] ramp;
  logic [RW-1:0] thr;
  logic          on_ph;
  logic [1:0]    nxt_a, nxt_b;

  assign thr   = duty_sel[0] ? HI_C : LO_C;
  assign on_ph = !duty_sel[1] || (ramp < thr);

  always_comb begin
    nxt_a = LEG_OFF;
    nxt_b = LEG_OFF;
    unique case ({dir_fwd, dir_rev})
      2'b10: begin nxt_a = on_ph ? LEG_HI : LEG_OFF; nxt_b = LEG_LO; end
      2'b01: begin nxt_a = LEG_LO; nxt_b = on_ph ? LEG_HI : LEG_OFF; end
      2'b11: begin nxt_a = LEG_LO; nxt_b = LEG_LO; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp         <= '0;
      leg_a        <= LEG_OFF;
      leg_b        <= LEG_OFF;
      lvl_low_pull <= 1'b0;
    end else begin
      ramp         <= (ramp == TOP_C) ? '0 : ramp + 1'b1;
      leg_a        <= nxt_a;
      leg_b        <= nxt_b;
      lvl_low_pull <= !duty_sel[0];
    end
  end

  assert_ramp_wrap_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    ramp == TOP_C |=> ramp == '0);
  assert_ramp_step_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    ramp != TOP_C |=> ramp == $past(ramp) + 1'b1);
  assert_idle_float_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_fwd && !dir_rev) |=> (leg_a == LEG_OFF && leg_b == LEG_OFF));
  assert_brake_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (dir_fwd && dir_rev) |=> (leg_a == LEG_LO && leg_b == LEG_LO));
  assert_full_on_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (dir_fwd && !dir_rev && !duty_sel[1]) |=> leg_a == LEG_HI);
  assert_low_off_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (dir_fwd && !dir_rev && duty_sel == 2'b10 && ramp >= LO_C) |=> leg_a == LEG_OFF);
  assert_flag_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    !duty_sel[0] |=> lvl_low_pull);
  assert_no_shoot_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    leg_a != 2'b11 && leg_b != 2'b11);

endmodule

// File: tb/tb_bridge_pwm.sv
module tb_bridge_pwm;
  localparam int TOP = 39;
  localparam int HI  = 30;
  localparam int LO  = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       dir_fwd = 1'b0;
  logic       dir_rev = 1'b0;
  logic [1:0] duty_sel = 2'b00;
  logic [1:0] leg_a, leg_b;
  logic       lvl_low_pull;

  bridge_pwm #(.RAMP_TOP(TOP), .THR_HI(HI), .THR_LO(LO), .MIN_THR(4)) dut (
    .clk(clk), .rst_n(rst_n), .dir_fwd(dir_fwd), .dir_rev(dir_rev),
    .duty_sel(duty_sel), .leg_a(leg_a), .leg_b(leg_b), .lvl_low_pull(lvl_low_pull)
  );

  always #10 clk = ~clk;

  int    vectors = 0;
  int    errors  = 0;
  int    mramp   = 0;
  logic [1:0] ea = 2'b00, eb = 2'b00;
  logic  ef = 1'b0;
  string tag = "R1";
  bit    armed = 0;
  bit    done  = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ea = 2'b00; eb = 2'b00; ef = 1'b0; mramp = 0; tag = "R1";
    end else begin
      bit on;
      on = !duty_sel[1] || (mramp < (duty_sel[0] ? HI : LO));
      ef = !duty_sel[0];
      case ({dir_fwd, dir_rev})
        2'b00: begin ea = 2'b00; eb = 2'b00; tag = "R3"; end
        2'b11: begin ea = 2'b10; eb = 2'b10; tag = "R9"; end
        2'b10: begin
          ea = on ? 2'b01 : 2'b00; eb = 2'b10;
          tag = !duty_sel[1] ? "R8 R4" : (on ? "R7 R4" : "R2 R7 R6");
        end
        default: begin
          ea = 2'b10; eb = on ? 2'b01 : 2'b00;
          tag = !duty_sel[1] ? "R8 R5" : (on ? "R7 R5" : "R2 R7 R6");
        end
      endcase
      mramp = (mramp == TOP) ? 0 : mramp + 1;
    end
    armed = 1;
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      vectors++;
      if (leg_a !== ea || leg_b !== eb) begin
        errors++;
        $display("FAIL %s legs actual a=%b b=%b expected a=%b b=%b", tag, leg_a, leg_b, ea, eb);
      end
      if (lvl_low_pull !== ef) begin
        errors++;
        $display("FAIL R10 flag actual %b expected %b", lvl_low_pull, ef);
      end
      if (leg_a === 2'b11 || leg_b === 2'b11) begin
        errors++;
        $display("FAIL R11 leg code actual a=%b b=%b expected not 11", leg_a, leg_b);
      end
    end
  end

  task automatic hold(input logic f, input logic r, input logic [1:0] s, input int n);
    @(negedge clk);
    dir_fwd = f; dir_rev = r; duty_sel = s;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    hold(0, 0, 2'b11, 50);
    hold(1, 0, 2'b11, 120);
    hold(1, 0, 2'b10, 120);
    hold(0, 1, 2'b11, 120);
    hold(0, 1, 2'b10, 100);
    hold(1, 0, 2'b00, 60);
    hold(0, 1, 2'b01, 60);
    hold(1, 1, 2'b11, 50);
    hold(0, 0, 2'b10, 40);
    hold(1, 0, 2'b11, 17);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    hold(1, 0, 2'b10, 90);
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      hold(lfsr[0], lfsr[1], lfsr[3:2], 1 + int'(lfsr[6:4]));
    end
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule